// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Plane

This block is the logic plane of a small programmable logic device with eight outputs. A set of input signals, some dedicated inputs and some fed back from the output cells, is presented to the plane in both true and inverted form, so every signal takes two columns. Each product-term row ANDs whichever columns its connection bits select. The rows are grouped into fixed bundles, one bundle per output, and each bundle is ORed into the sum that goes to that output's cell.

The connection map sits in a long shift register. While `cfg_load` is high, one bit enters per clock. When the load is over, the plane evaluates every cycle and presents all product terms and all sums on registered outputs. A per-row kill mask removes unused terms. A per-output flag leaves the last term of a bundle out of the sum, so that the output cell can use that term as its enable. In registered mode, two of the signals act as the device clock and output enable, and the plane stops treating them as data.

Top module: `pla_sop_array`

## Requirements
- R1: A synchronous active-high `rst` clears the whole connection map and sets `term_q` and `sum_q` to zero.
- R2: Each cycle with `cfg_load` high shifts `cfg_bit` into map bit 0 and moves every map bit up by one position. After 2048 loads, the first bit shifted in sits at bit 2047. Map bit `r*32+c` connects row `r` to column `c`. Column `2s` is signal `s` true and column `2s+1` is signal `s` inverted.
- R3: In the cycle after any cycle with `cfg_load` high, `term_q` and `sum_q` are all zero.
- R4: While `cfg_load` is low, the map does not change and `cfg_bit` has no effect on any output.
- R5: A row with no connection bits set gives 1.
- R6: A row connected to both the true and the inverted column of one signal gives 0.
- R7: `term_q[r]` is the AND of the columns selected in row `r`, based on the inputs sampled at the previous clock edge (one cycle of latency).
- R8: `sum_q[o]` is the OR of `term_q[8o]` through `term_q[8o+7]`.
- R9: When `sum_drop_last[o]` is 1, row `8o+7` is left out of `sum_q[o]`, and `term_q[8o+7]` still shows its value.
- R10: A row whose `term_kill` bit is 1 gives 0 on `term_q` and adds nothing to any sum.
- R11: When `reg_mode` is 1, signals 0 and 9 read as 1 in both their true and inverted columns. When `reg_mode` is 0, they behave like any other signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for evaluation and map loading |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Map shift enable; forces the outputs to zero |
| cfg_bit | input | 1 | Serial map data, first bit ends up as the MSB |
| sig_in | input | 16 | Signals presented to the plane |
| reg_mode | input | 1 | Registered mode: signals 0 and 9 are removed from the plane |
| term_kill | input | 64 | Per-row disable |
| sum_drop_last | input | 8 | Per-output: leave the last term of the bundle out of the sum |
| term_q | output | 64 | Registered product terms |
| sum_q | output | 8 | Registered sums, one per output |

## Verification
The bench builds the block with its default values: 16 signals, 8 outputs, 8 terms per output, and signals 0 and 9 shared with the clock and the output enable. With these values the full 2048-bit serial load is exercised, so a one-position slip in the MSB-first order shows up in the last row. The drop of the eighth term can be seen in a group that has no other active term. Rows connected to signals 0 and 9 show how the shared columns behave when the mode changes.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int unsigned COLS_PER_SIG = 2;
  typedef enum logic {
    POL_TRUE = 1'b0,
    POL_INV  = 1'b1
  } col_pol_e;
  function automatic int unsigned col_of(input int unsigned sig, input col_pol_e pol);
    return sig * COLS_PER_SIG + ((pol == POL_INV) ? 1 : 0);
  endfunction
endpackage

// File: rtl/pla_map_store.sv
module pla_map_store #(
  parameter int unsigned MAP_BITS = 2048
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_load,
  input  logic                cfg_bit,
  output logic [MAP_BITS-1:0] map_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      map_q <= '0;
    end else if (cfg_load) begin
      map_q <= {map_q[MAP_BITS-2:0], cfg_bit};
    end
  end

  // R4
  map_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> $stable(map_q));
endmodule

// File: rtl/pla_col_drv.sv
module pla_col_drv
  import pla_pkg::*;
#(
  parameter int unsigned N_SIG    = 16,
  parameter int unsigned SHARED_A = 0,
  parameter int unsigned SHARED_B = 9,
  localparam int unsigned N_COL   = N_SIG * COLS_PER_SIG
) (
  input  logic [N_SIG-1:0] sig_in,
  input  logic             reg_mode,
  output logic [N_COL-1:0] cols
);
  for (genvar s = 0; s < N_SIG; s++) begin : g_sig
    localparam bit IS_SHARED = (s == SHARED_A) || (s == SHARED_B);
    logic mask;
    assign mask = IS_SHARED && reg_mode;
    assign cols[col_of(s, POL_TRUE)] = mask | sig_in[s];
    assign cols[col_of(s, POL_INV)]  = mask | ~sig_in[s];
  end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int unsigned N_COL = 32,
  parameter int unsigned N_ROW = 64
) (
  input  logic [N_ROW*N_COL-1:0] map_q,
  input  logic [N_COL-1:0]       cols,
  input  logic [N_ROW-1:0]       term_kill,
  output logic [N_ROW-1:0]       terms
);
  for (genvar r = 0; r < N_ROW; r++) begin : g_row
    logic [N_COL-1:0] conn;
    assign conn = map_q[r*N_COL +: N_COL];
    assign terms[r] = ~term_kill[r] & (&(~conn | cols));
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int unsigned N_OUT = 8,
  parameter int unsigned TPO   = 8,
  localparam int unsigned N_ROW = N_OUT * TPO
) (
  input  logic [N_ROW-1:0] terms,
  input  logic [N_OUT-1:0] sum_drop_last,
  output logic [N_OUT-1:0] sums
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [TPO-1:0] keep;
    assign keep    = {~sum_drop_last[o], {(TPO-1){1'b1}}};
    assign sums[o] = |(terms[o*TPO +: TPO] & keep);
  end
endmodule

// File: rtl/pla_sop_array.sv
module pla_sop_array
  import pla_pkg::*;
#(
  parameter int unsigned N_SIG    = 16,
  parameter int unsigned N_OUT    = 8,
  parameter int unsigned TPO      = 8,
  parameter int unsigned SHARED_A = 0,
  parameter int unsigned SHARED_B = 9,
  localparam int unsigned N_COL    = N_SIG * COLS_PER_SIG,
  localparam int unsigned N_ROW    = N_OUT * TPO,
  localparam int unsigned MAP_BITS = N_ROW * N_COL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic             cfg_bit,
  input  logic [N_SIG-1:0] sig_in,
  input  logic             reg_mode,
  input  logic [N_ROW-1:0] term_kill,
  input  logic [N_OUT-1:0] sum_drop_last,
  output logic [N_ROW-1:0] term_q,
  output logic [N_OUT-1:0] sum_q
);
  logic [MAP_BITS-1:0] map_q;
  logic [N_COL-1:0]    cols;
  logic [N_ROW-1:0]    terms;
  logic [N_OUT-1:0]    sums;

  pla_map_store #(.MAP_BITS(MAP_BITS)) u_store (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_bit(cfg_bit), .map_q(map_q)
  );

  pla_col_drv #(.N_SIG(N_SIG), .SHARED_A(SHARED_A), .SHARED_B(SHARED_B)) u_cols (
    .sig_in(sig_in), .reg_mode(reg_mode), .cols(cols)
  );

  pla_and_plane #(.N_COL(N_COL), .N_ROW(N_ROW)) u_and (
    .map_q(map_q), .cols(cols), .term_kill(term_kill), .terms(terms)
  );

  pla_or_plane #(.N_OUT(N_OUT), .TPO(TPO)) u_or (
    .terms(terms), .sum_drop_last(sum_drop_last), .sums(sums)
  );

  always_ff @(posedge clk) begin
    if (rst || cfg_load) begin
      term_q <= '0;
      sum_q  <= '0;
    end else begin
      term_q <= terms;
      sum_q  <= sums;
    end
  end

  // R3
  load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> (term_q == '0) && (sum_q == '0));

  // R10
  kill_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (term_kill != '0) |=> ((term_q & $past(term_kill)) == '0));

  // R8
  sum_needs_term_chk: assert property (@(posedge clk) disable iff (rst)
    (term_q == '0) |-> (sum_q == '0));
endmodule

// File: tb/tb_pla_sop_array.sv
module tb_pla_sop_array;
  localparam int NS = 16, NO = 8, TP = 8, NC = 32, NR = 64, MB = 2048;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_load;
  logic          cfg_bit;
  logic [NS-1:0] sig_in;
  logic          reg_mode;
  logic [NR-1:0] term_kill;
  logic [NO-1:0] sum_drop_last;
  logic [NR-1:0] term_q;
  logic [NO-1:0] sum_q;

  int total = 0;
  int bad   = 0;
  logic [MB-1:0] cur_map;

  always #5 clk = ~clk;

  pla_sop_array dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_bit(cfg_bit),
    .sig_in(sig_in), .reg_mode(reg_mode), .term_kill(term_kill),
    .sum_drop_last(sum_drop_last), .term_q(term_q), .sum_q(sum_q)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NR-1:0] model_terms(input logic [MB-1:0] m, input logic [NS-1:0] s,
                                                input logic rm, input logic [NR-1:0] k);
    logic [NC-1:0] c;
    logic [NR-1:0] t;
    for (int i = 0; i < NS; i++) begin
      logic sh;
      sh = rm && (i == 0 || i == 9);
      c[2*i]   = sh | s[i];
      c[2*i+1] = sh | ~s[i];
    end
    for (int r = 0; r < NR; r++) begin
      t[r] = !k[r];
      for (int j = 0; j < NC; j++)
        if (m[r*NC+j] && !c[j]) t[r] = 1'b0;
    end
    return t;
  endfunction

  function automatic logic [NO-1:0] model_sums(input logic [NR-1:0] t, input logic [NO-1:0] d);
    logic [NO-1:0] o;
    for (int g = 0; g < NO; g++) begin
      o[g] = 1'b0;
      for (int j = 0; j < TP; j++)
        if (t[g*TP+j] && !(j == TP-1 && d[g])) o[g] = 1'b1;
    end
    return o;
  endfunction

  // drive at negedge, outputs registered at next posedge, sample at following negedge
  task automatic apply_and_check(input string tag, input logic [NS-1:0] s, input logic rm,
                                 input logic [NR-1:0] k, input logic [NO-1:0] d);
    logic [NR-1:0] et;
    @(negedge clk);
    sig_in = s; reg_mode = rm; term_kill = k; sum_drop_last = d;
    @(negedge clk);
    et = model_terms(cur_map, s, rm, k);
    chk({tag, " terms"}, 64'(term_q), 64'(et));
    chk({tag, " sums"}, 64'(sum_q), 64'(model_sums(et, d)));
  endtask

  function automatic logic [MB-1:0] build_map();
    logic [MB-1:0] m;
    m = '0;
    for (int r = 0; r < NR; r++) begin
      m[r*NC+30] = 1'b1;
      m[r*NC+31] = 1'b1;
    end
    m[0*NC +: NC] = '0; m[0*NC+2] = 1'b1; m[0*NC+5] = 1'b1;   // s1 & ~s2
    m[1*NC +: NC] = '0; m[1*NC+6] = 1'b1; m[1*NC+7] = 1'b1;   // s3 & ~s3
    m[7*NC +: NC] = '0; m[7*NC+8] = 1'b1;                     // s4
    m[8*NC +: NC] = '0; m[8*NC+0] = 1'b1; m[8*NC+10] = 1'b1;  // s0 & s5
    m[9*NC +: NC] = '0; m[9*NC+19] = 1'b1;                    // ~s9
    m[16*NC +: NC] = '0;                                      // blank
    return m;
  endfunction

  task automatic t_reset();
    rst = 1'b1; cfg_load = 1'b0; cfg_bit = 1'b0; sig_in = '0; reg_mode = 1'b0;
    term_kill = '0; sum_drop_last = '0; cur_map = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset terms", 64'(term_q), 64'h0);
    chk("R1 reset sums", 64'(sum_q), 64'h0);
    rst = 1'b0;
    apply_and_check("R5 blank map", 16'h1234, 1'b0, '0, '0);
    chk("R5 blank all ones", 64'(term_q), {64{1'b1}});
  endtask

  task automatic t_load(input logic [MB-1:0] m);
    @(negedge clk);
    cfg_load = 1'b1;
    for (int i = MB - 1; i >= 0; i--) begin
      cfg_bit = m[i];
      @(negedge clk);
      if (i == MB - 5) begin
        chk("R3 outputs quiet during load", 64'(term_q), 64'h0);
        chk("R3 sums quiet during load", 64'(sum_q), 64'h0);
      end
    end
    cfg_load = 1'b0;
    cur_map = m;
  endtask

  task automatic t_logic();
    apply_and_check("R7 pattern a", 16'h0002, 1'b0, '0, '0);
    chk("R7 row0 s1&~s2 high", 64'(term_q[0]), 64'd1);
    chk("R8 sum0 high", 64'(sum_q[0]), 64'd1);
    apply_and_check("R7 pattern b", 16'h0006, 1'b0, '0, '0);
    chk("R7 row0 low", 64'(term_q[0]), 64'd0);
    chk("R2 last row low", 64'(term_q[63]), 64'd0);
    apply_and_check("R6 pattern c", 16'h0008, 1'b0, '0, '0);
    chk("R6 contradiction row1", 64'(term_q[1]), 64'd0);
    apply_and_check("R6 pattern d", 16'h0000, 1'b0, '0, '0);
    chk("R6 contradiction row1 again", 64'(term_q[1]), 64'd0);
    chk("R5 blank row16", 64'(term_q[16]), 64'd1);
    chk("R8 sum2 from blank row", 64'(sum_q[2]), 64'd1);
    apply_and_check("R8 pattern e", 16'h0021, 1'b0, '0, '0);
    chk("R8 sum1 from row8", 64'(sum_q[1]), 64'd1);
  endtask

  task automatic t_drop();
    apply_and_check("R9 drop off", 16'h0010, 1'b0, '0, 8'h00);
    chk("R9 sum0 via row7", 64'(sum_q[0]), 64'd1);
    apply_and_check("R9 drop on", 16'h0010, 1'b0, '0, 8'h01);
    chk("R9 sum0 without row7", 64'(sum_q[0]), 64'd0);
    chk("R9 row7 still visible", 64'(term_q[7]), 64'd1);
  endtask

  task automatic t_kill();
    apply_and_check("R10 kill row0", 16'h0002, 1'b0, 64'h1, '0);
    chk("R10 row0 killed", 64'(term_q[0]), 64'd0);
    chk("R10 sum0 killed", 64'(sum_q[0]), 64'd0);
    apply_and_check("R10 kill blank row16", 16'h0000, 1'b0, 64'h1_0000, '0);
    chk("R10 sum2 killed", 64'(sum_q[2]), 64'd0);
  endtask

  task automatic t_regmode();
    apply_and_check("R11 comb mode", 16'h0220, 1'b0, '0, '0);
    chk("R11 row8 needs s0", 64'(term_q[8]), 64'd0);
    chk("R11 row9 sees s9", 64'(term_q[9]), 64'd0);
    apply_and_check("R11 reg mode", 16'h0220, 1'b1, '0, '0);
    chk("R11 row8 s0 masked", 64'(term_q[8]), 64'd1);
    chk("R11 row9 s9 masked", 64'(term_q[9]), 64'd1);
  endtask

  task automatic t_hold();
    logic [NR-1:0] t0;
    apply_and_check("R4 base", 16'h0002, 1'b0, '0, '0);
    t0 = term_q;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cfg_bit = i[0];
    end
    @(negedge clk);
    chk("R4 cfg_bit ignored", 64'(term_q), 64'(t0));
    apply_and_check("R4 map intact", 16'h0002, 1'b0, '0, '0);
  endtask

  initial begin
    t_reset();
    t_load(build_map());
    chk("R3 first cycle after load", 64'(term_q), 64'h0);
    t_logic();
    t_drop();
    t_kill();
    t_regmode();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule